// File: doc/BRIEF.md
# Laser Transmit Enable and Fault Controller

This block sequences the transmit side of a pluggable optical module. It watches the supply-good flag, the host's transmit-disable line and a raw fault request from the laser safety monitor. From these it drives a laser-enable output and a latched fault flag. After power comes up, or after a fault has been reset, it runs a timed initialisation window with the laser dark. It then lights the laser, unless the host is holding it off.

When a fault request arrives, the laser is shut off and the fault flag is latched high. Only a deliberate reset gesture from the host clears it: the disable line must be held high for a minimum number of cycles and then released. The block then retries with a fresh initialisation window. If the fault is still present during that window, the flag stays set and the laser stays dark. Every time limit is a parameter counted in clock cycles. The disable input passes through a two-stage synchroniser whose reset value models the module's pull-up, so an undriven line reads as "disabled".

Top module: `tx_laser_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, both outputs are low. The synchroniser stages hold the pull-up level DIS_PULL (default 1, meaning disabled).
- R2: Whenever power-good is low, both outputs are low on the next cycle. When power-good returns, a new initialisation window starts.
- R3: Initialisation lasts INIT_CYC cycles. During it, laser enable and the fault flag are both low. At its end the controller enters run (laser enable high) if the synchronised disable is low, and the disabled state (laser off) if it is high.
- R4: Disable is active high. A rising edge on the disable input drops laser enable exactly 3 cycles later: 2 synchroniser stages plus 1 output register. A falling edge while in the disabled state raises laser enable 3 cycles later.
- R5: A fault request seen while powered and not already in a fault or power-off state raises the fault flag and clears laser enable on the next cycle.
- R6: In the fault state, the flag stays high and the laser stays off until the synchronised disable has been high for at least RST_MIN_CYC consecutive cycles and then goes low. A shorter disable pulse is ignored and leaves the fault latched.
- R7: A valid reset starts a retry window of INIT_CYC cycles. During it the fault flag stays high and the laser stays off. A fault request inside the window returns to the fault state. Otherwise the flag clears when the window ends, and the controller enters run or disabled as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply above threshold |
| tx_disable_i | input | 1 | Host transmit disable, asynchronous, high = off |
| fault_req_i | input | 1 | Raw fault request from the safety monitor |
| laser_en_o | output | 1 | Laser enable, registered |
| tx_fault_o | output | 1 | Latched fault flag, registered, high = fault |

## Verification
The controller is exercised with these stimuli:
- A power-up with disable low, and another with disable held high, which separates the two exits from initialisation.
- A plain disable pulse in run, which fixes the three-cycle enable latency in each direction.
- A reset pulse one cycle shorter than the minimum and one well beyond it. Together these show that pulse length, and not edge count, clears a latched fault.
- A retry with the fault request held, compared against one where the fault has gone.
- A power-good drop in mid-run, which shows that the supply overrides every other state.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_INIT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DIS   = 3'd3,
    ST_FAULT = 3'd4,
    ST_RETRY = 3'd5
  } tlc_state_e;
endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tlc_counter.sv
module tlc_counter #(
  parameter int CW   = 4,
  parameter int CMAX = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(CMAX);

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt_o <= '0;
    else if (en_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  // R6: the hold count saturates and never wraps past its ceiling
  a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == TOP && !clr_i) |=> cnt_o == TOP);
endmodule

// File: rtl/tlc_fsm.sv
module tlc_fsm
  import tlc_pkg::*;
#(
  parameter int INIT_CYC    = 12,
  parameter int RST_MIN_CYC = 6,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_good_i,
  input  logic          dis_s_i,
  input  logic          fault_req_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          laser_en_o,
  output logic          tx_fault_o
);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] HOLD_MIN  = CW'(RST_MIN_CYC);

  tlc_state_e state, nxt;

  always_comb begin
    nxt = state;
    if (!pwr_good_i) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   nxt = ST_INIT;
        ST_INIT, ST_RETRY: begin
          if (fault_req_i)             nxt = ST_FAULT;
          else if (cnt_i == INIT_LAST) nxt = dis_s_i ? ST_DIS : ST_RUN;
        end
        ST_RUN: begin
          if (fault_req_i)  nxt = ST_FAULT;
          else if (dis_s_i) nxt = ST_DIS;
        end
        ST_DIS: begin
          if (fault_req_i)   nxt = ST_FAULT;
          else if (!dis_s_i) nxt = ST_RUN;
        end
        ST_FAULT: begin
          if (!dis_s_i && cnt_i >= HOLD_MIN) nxt = ST_RETRY;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    cnt_clr_o = (nxt != state) || (state == ST_FAULT && !dis_s_i);
    cnt_en_o  = (state == ST_INIT) || (state == ST_RETRY) ||
                (state == ST_FAULT && dis_s_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      laser_en_o <= 1'b0;
      tx_fault_o <= 1'b0;
    end else begin
      state      <= nxt;
      laser_en_o <= (nxt == ST_RUN);
      tx_fault_o <= (nxt == ST_FAULT) || (nxt == ST_RETRY);
    end
  end

  a_r2_power_loss_darkens: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (!laser_en_o && !tx_fault_o));

  a_r4_disable_darkens: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && dis_s_i) |=> !laser_en_o);

  a_r5_fault_latches: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && fault_req_i && state != ST_OFF) |=> (tx_fault_o && !laser_en_o));

  a_r6_short_pulse_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT && pwr_good_i && (dis_s_i || cnt_i < HOLD_MIN))
      |=> (tx_fault_o && !laser_en_o));

  a_r3_outputs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(laser_en_o && tx_fault_o));
endmodule

// File: rtl/tx_laser_ctrl.sv
module tx_laser_ctrl #(
  parameter int   INIT_CYC    = 12,
  parameter int   RST_MIN_CYC = 6,
  parameter int   SYNC_STAGES = 2,
  parameter logic DIS_PULL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic tx_disable_i,
  input  logic fault_req_i,
  output logic laser_en_o,
  output logic tx_fault_o
);
  localparam int CMAX = (INIT_CYC > RST_MIN_CYC) ? INIT_CYC : RST_MIN_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic          dis_s;
  logic          cnt_clr, cnt_en;
  logic [CW-1:0] cnt;

  tlc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(DIS_PULL)) u_sync (
    .clk(clk), .rst(rst), .d_i(tx_disable_i), .q_o(dis_s)
  );

  tlc_counter #(.CW(CW), .CMAX(CMAX)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .en_i(cnt_en), .cnt_o(cnt)
  );

  tlc_fsm #(.INIT_CYC(INIT_CYC), .RST_MIN_CYC(RST_MIN_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .dis_s_i(dis_s),
    .fault_req_i(fault_req_i), .cnt_i(cnt), .cnt_clr_o(cnt_clr),
    .cnt_en_o(cnt_en), .laser_en_o(laser_en_o), .tx_fault_o(tx_fault_o)
  );

  // R1: both outputs are low on the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!laser_en_o && !tx_fault_o));
endmodule

// File: tb/tx_laser_ctrl_tb.sv
module tx_laser_ctrl_tb;
  localparam int INIT_CYC = 12;
  localparam int RST_MIN  = 6;
  localparam int HOLD_TOP = (INIT_CYC > RST_MIN) ? INIT_CYC : RST_MIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good_i = 1'b0;
  logic tx_disable_i = 1'b1;
  logic fault_req_i = 1'b0;
  logic laser_en_o, tx_fault_o;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  always #2ns clk = ~clk;

  tx_laser_ctrl #(.INIT_CYC(INIT_CYC), .RST_MIN_CYC(RST_MIN)) u_dut (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .tx_disable_i(tx_disable_i),
    .fault_req_i(fault_req_i), .laser_en_o(laser_en_o), .tx_fault_o(tx_fault_o)
  );

  // Behavioural reference: mode names as strings, elapsed-time integer, delay queue
  string mode = "off";
  int    elapsed = 0;
  bit    dq[$] = '{1'b1, 1'b1};

  always @(posedge clk) begin
    string nm;
    bit seen;
    if (rst) begin
      mode = "off"; elapsed = 0; dq = '{1'b1, 1'b1};
    end else begin
      seen = dq[0];
      nm = mode;
      if (!pwr_good_i) nm = "off";
      else if (mode == "off") nm = "init";
      else if (mode == "init" || mode == "retry") begin
        if (fault_req_i) nm = "fault";
        else if (elapsed == INIT_CYC - 1) nm = seen ? "dis" : "run";
      end else if (mode == "run") begin
        if (fault_req_i) nm = "fault"; else if (seen) nm = "dis";
      end else if (mode == "dis") begin
        if (fault_req_i) nm = "fault"; else if (!seen) nm = "run";
      end else if (mode == "fault") begin
        if (!seen && elapsed >= RST_MIN) nm = "retry";
      end
      if (nm != mode || (mode == "fault" && !seen)) elapsed = 0;
      else if ((mode == "init" || mode == "retry" || (mode == "fault" && seen))
               && elapsed < HOLD_TOP) elapsed++;
      mode = nm;
      void'(dq.pop_front());
      dq.push_back(tx_disable_i);
    end
  end

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(phase, laser_en_o, mode == "run", "laser_en_o vs model");
    check(phase, tx_fault_o, mode == "fault" || mode == "retry", "tx_fault_o vs model");
  end

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_report();
  end

  initial begin
    phase = "R1";
    cyc(3);
    check("R1", laser_en_o, 1'b0, "laser in reset");
    check("R1", tx_fault_o, 1'b0, "fault in reset");
    rst = 1'b0;
    cyc(2);
    check("R1", laser_en_o, 1'b0, "laser after reset");

    phase = "R3"; pwr_good_i = 1'b1; tx_disable_i = 1'b0;
    cyc(5);
    check("R3", laser_en_o, 1'b0, "laser dark in init");
    cyc(INIT_CYC + 4);
    check("R3", laser_en_o, 1'b1, "laser on after init");

    phase = "R4"; tx_disable_i = 1'b1;
    cyc(2);
    check("R4", laser_en_o, 1'b1, "still on 2 cycles after disable");
    cyc(1);
    check("R4", laser_en_o, 1'b0, "off 3 cycles after disable");
    cyc(4); tx_disable_i = 1'b0;
    cyc(3);
    check("R4", laser_en_o, 1'b1, "on 3 cycles after release");

    phase = "R5"; fault_req_i = 1'b1; cyc(1); fault_req_i = 1'b0;
    cyc(1);
    check("R5", tx_fault_o, 1'b1, "fault latched");
    check("R5", laser_en_o, 1'b0, "laser shut by fault");

    phase = "R6"; tx_disable_i = 1'b1; cyc(RST_MIN - 1); tx_disable_i = 1'b0;
    cyc(INIT_CYC + 6);
    check("R6", tx_fault_o, 1'b1, "short pulse ignored");
    check("R6", laser_en_o, 1'b0, "laser stays dark");

    phase = "R7"; tx_disable_i = 1'b1; cyc(RST_MIN + 3); tx_disable_i = 1'b0;
    cyc(5);
    check("R7", tx_fault_o, 1'b1, "flag held during retry");
    cyc(INIT_CYC + 4);
    check("R7", tx_fault_o, 1'b0, "transient fault cleared");
    check("R7", laser_en_o, 1'b1, "laser restored");

    fault_req_i = 1'b1; cyc(2);
    tx_disable_i = 1'b1; cyc(RST_MIN + 3); tx_disable_i = 1'b0;
    cyc(INIT_CYC + 6);
    check("R7", tx_fault_o, 1'b1, "persistent fault re-latched");
    check("R7", laser_en_o, 1'b0, "persistent fault keeps laser dark");
    fault_req_i = 1'b0;

    phase = "R2"; pwr_good_i = 1'b0; cyc(1);
    check("R2", tx_fault_o, 1'b0, "power loss clears flag");
    cyc(3);
    phase = "R3"; tx_disable_i = 1'b1; pwr_good_i = 1'b1;
    cyc(INIT_CYC + 5);
    check("R3", laser_en_o, 1'b0, "init exits to disabled");
    tx_disable_i = 1'b0; cyc(5);
    check("R3", laser_en_o, 1'b1, "disabled to run");
    phase = "R2"; pwr_good_i = 1'b0; cyc(1);
    check("R2", laser_en_o, 1'b0, "power loss darkens laser");
    cyc(4);
    finish_report();
  end
endmodule